// File: doc/BRIEF.md
# SAR ADC Autoscan Sequencer

This block is the digital control for a 10-bit successive-approximation converter with eight multiplexed analog inputs. It reads a channel-select mask and visits every enabled channel in ascending index order. For each channel it drives the analog mux select and a 10-bit trial code for the DAC. It samples one comparator bit for each bit period and stores the finished code in that channel's own result register. The analog parts are outside the block. Only the comparator output comes back in.

A scan loop is started by a software pulse or by a rising edge on an external start pin. The external pin only counts while its enable is set. A loop can run once, or it can repeat while continuous mode is held. An interrupt pulse marks the end of every loop. The bit period comes from the system clock through a prescaler that divides by 2, 4, 6 or 8.

Results are read one channel at a time. The low byte is returned combinationally. The upper two bits are latched into one shared register at the moment of the low-byte read, so a low/high pair always comes from the same conversion.

Top module: `sar_scan_ctrl`

## Requirements
- R1: After reset, busy_o, irq_o and rd_high_o are 0, and every channel's result reads 0.
- R2: Each conversion presents dac_code_o = 0x200 in its first bit period. It then trials the bits from MSB to LSB, one comparator sample per bit period, and keeps a bit when cmp_i = 1 (input at or above the DAC level). With an ideal comparator the stored result equals the input code.
- R3: While busy_o is 1, mux_sel_o holds the index of the channel being converted. The enabled channels (mask bit i = 1 enables channel i) are visited in ascending index order, and cleared bits are skipped. The mask is sampled when each loop starts.
- R4: A start request (software or external) with an all-zero mask starts nothing, and busy_o stays 0.
- R5: With cont_i = 0 at the end of a loop, busy_o falls in the cycle after the last conversion's final bit period.
- R6: With cont_i = 1 at the end of a loop and a non-zero mask, a new loop starts at once. Clearing cont_i ends scanning after the current loop.
- R7: A 0-to-1 transition of ext_start_i starts a loop only when ext_en_i = 1. With ext_en_i = 0 it has no effect.
- R8: Each conversion takes 10 bit periods. A bit period is 2*(presc_sel_i+1) clock cycles: code 0 gives 2, 1 gives 4, 2 gives 6 and 3 gives 8.
- R9: A channel's result register changes only when that channel completes a conversion. It holds that channel's last result.
- R10: rd_low_o is bits 7:0 of the result selected by rd_chan_i. On a clock with rd_en_i = 1, rd_high_o loads bits 9:8 of that same result. Otherwise rd_high_o holds its value.
- R11: Start requests that arrive while busy_o is 1 are ignored.
- R12: irq_o is a one-cycle pulse in the cycle after the last enabled channel of each loop completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_mask_i | input | 8 | Channel enable mask, bit i enables channel i |
| start_i | input | 1 | Software start pulse |
| cont_i | input | 1 | 1 = continuous scanning, 0 = single loop |
| ext_en_i | input | 1 | Enables the external start pin |
| ext_start_i | input | 1 | External start, acts on a rising edge |
| presc_sel_i | input | 2 | Prescaler select, divide by 2*(code+1) |
| cmp_i | input | 1 | Comparator output, 1 = input at or above DAC level |
| mux_sel_o | output | 3 | Analog mux channel select |
| dac_code_o | output | 10 | DAC trial code |
| busy_o | output | 1 | A scan loop is in progress |
| irq_o | output | 1 | End-of-loop interrupt pulse |
| rd_en_i | input | 1 | Read strobe, latches the upper bits |
| rd_chan_i | input | 3 | Channel selected for reading |
| rd_low_o | output | 8 | Low byte of the selected result |
| rd_high_o | output | 2 | Latched upper two bits |

## Verification
The properties assume that presc_sel_i stays steady while a loop runs. They also assume that cmp_i depends only on the current mux select and DAC code, as an ideal comparator does. The bench keeps the prescaler and per-channel input values unchanged while busy_o is high, and it changes them only between loops. It derives the comparator from the DAC code. It performs reads only while the block is idle, so the expected results do not move under a read.

// File: rtl/sar_scan_pkg.sv
package sar_scan_pkg;
  localparam int unsigned LOW_W = 8;
  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} scan_st_e;
endpackage

// File: rtl/scan_presc.sv
module scan_presc #(
  parameter int unsigned SEL_W = 2,
  localparam int unsigned CNT_W = SEL_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim    = {sel_i, 1'b1};  // 2*(sel+1)-1
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sar_core.sv
module sar_core #(
  parameter int unsigned RES_W = 10,
  localparam int unsigned IDX_W = $clog2(RES_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] code_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);
  logic [RES_W-1:0] code_q, kept, trial;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    kept = code_q;
    kept[idx_q] = cmp_i;
    trial = '0;
    if (idx_q != '0) trial[idx_q - 1'b1] = 1'b1;
  end

  assign code_o   = code_q;
  assign result_o = kept;
  assign done_o   = tick_i && (idx_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      code_q <= {1'b1, {(RES_W-1){1'b0}}};
      idx_q  <= IDX_W'(RES_W - 1);
    end else if (tick_i) begin
      code_q <= kept | trial;
      if (idx_q != '0) idx_q <= idx_q - 1'b1;
    end
  end
endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import sar_scan_pkg::*;
#(
  parameter int unsigned N_CH = 8,
  localparam int unsigned CH_W = $clog2(N_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trig_i,
  input  logic [N_CH-1:0] mask_i,
  input  logic            cont_i,
  input  logic            done_i,
  output logic            busy_o,
  output logic [CH_W-1:0] chan_o,
  output logic            load_o,
  output logic            wr_o,
  output logic            loop_end_o
);
  scan_st_e        st_q;
  logic [CH_W-1:0] chan_q, pick;
  logic [N_CH-1:0] pend_q, src, pend_d;
  logic            start, step, restart;

  assign busy_o     = (st_q == ST_BUSY);
  assign start      = !busy_o && trig_i && (|mask_i);
  assign wr_o       = busy_o && done_i;
  assign step       = wr_o && (|pend_q);
  assign loop_end_o = wr_o && !(|pend_q);
  assign restart    = loop_end_o && cont_i && (|mask_i);
  assign load_o     = start || step || restart;
  assign src        = step ? pend_q : mask_i;
  assign chan_o     = chan_q;

  // lowest set bit wins
  always_comb begin
    pick = '0;
    for (int i = N_CH - 1; i >= 0; i--)
      if (src[i]) pick = CH_W'(i);
    pend_d = src;
    pend_d[pick] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      chan_q <= '0;
      pend_q <= '0;
    end else if (load_o) begin
      st_q   <= ST_BUSY;
      chan_q <= pick;
      pend_q <= pend_d;
    end else if (loop_end_o) begin
      st_q   <= ST_IDLE;
    end
  end
endmodule

// File: rtl/result_file.sv
module result_file
  import sar_scan_pkg::*;
#(
  parameter int unsigned N_CH  = 8,
  parameter int unsigned RES_W = 10,
  localparam int unsigned CH_W = $clog2(N_CH),
  localparam int unsigned HI_W = RES_W - LOW_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CH_W-1:0]  wr_ch_i,
  input  logic [RES_W-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic [CH_W-1:0]  rd_ch_i,
  output logic [LOW_W-1:0] rd_low_o,
  output logic [HI_W-1:0]  rd_high_o
);
  logic [RES_W-1:0] res_q [N_CH];
  logic [HI_W-1:0]  hi_q;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               res_q[g] <= '0;
      else if (wr_i && (wr_ch_i == CH_W'(g)))    res_q[g] <= wr_data_i;
    end
  end

  assign rd_low_o  = res_q[rd_ch_i][LOW_W-1:0];
  assign rd_high_o = hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_q <= '0;
    else if (rd_en_i) hi_q <= res_q[rd_ch_i][RES_W-1:LOW_W];
  end
endmodule

// File: rtl/sar_scan_ctrl.sv
module sar_scan_ctrl
  import sar_scan_pkg::*;
#(
  parameter int unsigned N_CH  = 8,
  parameter int unsigned RES_W = 10,
  parameter int unsigned SEL_W = 2,
  localparam int unsigned CH_W = $clog2(N_CH),
  localparam int unsigned HI_W = RES_W - LOW_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CH-1:0]  chan_mask_i,
  input  logic             start_i,
  input  logic             cont_i,
  input  logic             ext_en_i,
  input  logic             ext_start_i,
  input  logic [SEL_W-1:0] presc_sel_i,
  input  logic             cmp_i,
  output logic [CH_W-1:0]  mux_sel_o,
  output logic [RES_W-1:0] dac_code_o,
  output logic             busy_o,
  output logic             irq_o,
  input  logic             rd_en_i,
  input  logic [CH_W-1:0]  rd_chan_i,
  output logic [LOW_W-1:0] rd_low_o,
  output logic [HI_W-1:0]  rd_high_o
);
  logic             ext_q, irq_q, trig;
  logic             tick, load, done, wr, loop_end;
  logic [RES_W-1:0] result;

  assign trig  = start_i || (ext_en_i && ext_start_i && !ext_q);
  assign irq_o = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ext_q <= ext_start_i;
      irq_q <= loop_end;
    end
  end

  scan_presc #(.SEL_W(SEL_W)) u_presc (
    .clk_i, .rst_ni, .run_i(busy_o), .sel_i(presc_sel_i), .tick_o(tick)
  );

  scan_seq #(.N_CH(N_CH)) u_seq (
    .clk_i, .rst_ni, .trig_i(trig), .mask_i(chan_mask_i), .cont_i,
    .done_i(done), .busy_o, .chan_o(mux_sel_o), .load_o(load),
    .wr_o(wr), .loop_end_o(loop_end)
  );

  sar_core #(.RES_W(RES_W)) u_sar (
    .clk_i, .rst_ni, .load_i(load), .tick_i(tick), .cmp_i,
    .code_o(dac_code_o), .done_o(done), .result_o(result)
  );

  result_file #(.N_CH(N_CH), .RES_W(RES_W)) u_res (
    .clk_i, .rst_ni, .wr_i(wr), .wr_ch_i(mux_sel_o), .wr_data_i(result),
    .rd_en_i, .rd_ch_i(rd_chan_i), .rd_low_o, .rd_high_o
  );
endmodule

// File: rtl/sar_scan_ctrl_chk.sv
module sar_scan_ctrl_chk #(
  parameter int unsigned N_CH  = 8,
  parameter int unsigned RES_W = 10,
  parameter int unsigned HI_W  = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_CH-1:0]  chan_mask_i,
  input logic             start_i,
  input logic             ext_en_i,
  input logic             cont_i,
  input logic             rd_en_i,
  input logic             busy_o,
  input logic             irq_o,
  input logic [RES_W-1:0] dac_code_o,
  input logic [HI_W-1:0]  rd_high_o
);
  p_first_trial_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> dac_code_o == {1'b1, {(RES_W-1){1'b0}}});

  p_zero_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && chan_mask_i == '0) |=> !busy_o);

  p_single_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !$past(cont_i)) |-> !busy_o);

  p_ext_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i && !ext_en_i) |=> !busy_o);

  p_high_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_high_o));

  p_irq_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

bind sar_scan_ctrl sar_scan_ctrl_chk #(.N_CH(N_CH), .RES_W(RES_W), .HI_W(HI_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .chan_mask_i(chan_mask_i), .start_i(start_i),
  .ext_en_i(ext_en_i), .cont_i(cont_i), .rd_en_i(rd_en_i), .busy_o(busy_o),
  .irq_o(irq_o), .dac_code_o(dac_code_o), .rd_high_o(rd_high_o)
);

// File: tb/sar_scan_ctrl_test.sv
`timescale 1ns/1ps
module sar_scan_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mask = '0;
  logic       start = 1'b0, cont = 1'b0, ext_en = 1'b0, ext = 1'b0;
  logic [1:0] sel = '0;
  logic       cmp;
  logic [2:0] mux;
  logic [9:0] dac;
  logic       busy, irq;
  logic       rd_en = 1'b0;
  logic [2:0] rd_ch = '0;
  logic [7:0] rd_low;
  logic [1:0] rd_high;

  int vin [8];
  int errors = 0, checks = 0, cyc = 0, irq_cnt = 0;

  always #2 clk = ~clk;

  assign cmp = (vin[mux] >= int'(dac));

  sar_scan_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .chan_mask_i(mask), .start_i(start),
    .cont_i(cont), .ext_en_i(ext_en), .ext_start_i(ext), .presc_sel_i(sel),
    .cmp_i(cmp), .mux_sel_o(mux), .dac_code_o(dac), .busy_o(busy),
    .irq_o(irq), .rd_en_i(rd_en), .rd_chan_i(rd_ch), .rd_low_o(rd_low),
    .rd_high_o(rd_high)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int  m_busy = 0, m_chan = 0, m_cnt = 0, m_irq = 0, m_ext = 0;
  int  m_res [8];
  int  q [$];

  function automatic void fill_q();
    q.delete();
    for (int i = 0; i < 8; i++) if (mask[i]) q.push_back(i);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_chan = 0; m_cnt = 0; m_irq = 0; m_ext = 0;
      for (int i = 0; i < 8; i++) m_res[i] = 0;
    end else begin
      bit rise;
      rise  = ext_en && ext && (m_ext == 0);
      m_ext = ext;
      m_irq = 0;
      if (m_busy == 0) begin
        if ((start || rise) && mask != 0) begin
          fill_q(); m_chan = q.pop_front(); m_busy = 1; m_cnt = 0;
        end
      end else begin
        m_cnt++;
        if (m_cnt == 10 * 2 * (int'(sel) + 1)) begin
          m_res[m_chan] = vin[m_chan];
          m_cnt = 0;
          if (q.size() != 0) m_chan = q.pop_front();
          else begin
            m_irq = 1;
            if (cont && mask != 0) begin fill_q(); m_chan = q.pop_front(); end
            else m_busy = 0;
          end
        end
      end
    end
  end

  // per-clock compare
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check(busy == (m_busy != 0), "R5 R8 busy", busy, m_busy);
      check(irq == (m_irq != 0), "R12 irq", irq, m_irq);
      if (irq) irq_cnt++;
      if (m_busy != 0) begin
        check(int'(mux) == m_chan, "R3 mux", mux, m_chan);
        if (m_cnt == 0) check(dac == 10'h200, "R2 first trial", dac, 10'h200);
      end
    end
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic read_ch(input int ch, input string req);
    @(negedge clk);
    rd_ch = 3'(ch); rd_en = 1'b1;
    #0.5;
    check(int'(rd_low) == (m_res[ch] & 8'hFF), req, rd_low, m_res[ch] & 8'hFF);
    @(negedge clk);
    rd_en = 1'b0;
    check(int'(rd_high) == (m_res[ch] >> 8), req, rd_high, m_res[ch] >> 8);
  endtask

  initial begin
    int base;
    vin = '{10'h3FF, 10'h000, 10'h155, 10'h2AA, 10'h200, 10'h1FF, 10'h001, 10'h37C};
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(rd_high == 2'b0, "R1 rd_high", rd_high, 0);
    check(rd_low == 8'h0, "R1 rd_low", rd_low, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 zero mask
    mask = 8'h00; pulse_start();
    repeat (10) @(negedge clk);
    check(busy == 1'b0, "R4 zero mask", busy, 0);

    // one-shot, sparse mask, /2
    base = irq_cnt;
    mask = 8'b1010_0101; sel = 2'd0; pulse_start();
    wait_idle();
    check(irq_cnt - base == 1, "R5 one loop irq", irq_cnt - base, 1);
    for (int c = 0; c < 8; c++) read_ch(c, "R9 R2 sparse read");

    // R7 external start gated off
    ext_en = 1'b0; mask = 8'hFF; sel = 2'd3;
    @(negedge clk) ext = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R7 ext disabled", busy, 0);
    ext = 1'b0; @(negedge clk);
    ext_en = 1'b1;
    @(negedge clk) ext = 1'b1;
    @(negedge clk);
    check(busy == 1'b1, "R7 ext enabled", busy, 1);
    repeat (30) @(negedge clk);
    base = irq_cnt;
    pulse_start();  // R11 ignored while busy
    @(negedge clk) ext = 1'b0;
    @(negedge clk) ext = 1'b1;  // R11 edge while busy
    wait_idle();
    check(irq_cnt - base == 1, "R11 busy triggers ignored", irq_cnt - base, 1);
    ext = 1'b0; ext_en = 1'b0;
    for (int c = 0; c < 8; c++) read_ch(c, "R2 full read");

    // R10 coherence across a new conversion of the same channel
    read_ch(7, "R10 latch");
    vin[7] = 10'h005;
    mask = 8'h80; sel = 2'd1; cont = 1'b1;
    base = irq_cnt;
    pulse_start();
    while (irq_cnt - base < 3) @(negedge clk);
    check(busy == 1'b1, "R6 continuous still busy", busy, 1);
    check(rd_high == 2'd3, "R10 high held", rd_high, 3);
    cont = 1'b0;
    wait_idle();
    check(rd_high == 2'd3, "R10 high held idle", rd_high, 3);
    read_ch(7, "R10 R9 new value");

    // /6, two channels, boundary values
    vin[0] = 10'h000; vin[3] = 10'h3FE;
    mask = 8'h09; sel = 2'd2;
    pulse_start();
    wait_idle();
    read_ch(0, "R2 zero input");
    read_ch(3, "R2 near full scale");
    read_ch(7, "R9 untouched");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule